// File: doc/BRIEF.md
# Configurable PCM Highway Serial Port

This block moves one 8-bit voice sample each way per frame on a time-division PCM highway. An external data clock and an 8 kHz frame sync pulse come in asynchronously. The port oversamples them with its own system clock and turns each data clock transition into a one-cycle event. Each frame starts at a detected sync. The port then counts data clock cycles and finds the eight data periods of its chosen time slot. In that slot it shifts out the transmit byte, MSB first, and drives a tristate enable. In the same slot it collects a receive byte and presents it with a one-cycle valid strobe.

Several configuration inputs shape the timing. They choose one or two data clock cycles per bit and pick the clock edge that launches transmit data and the edge that samples receive data. In single-clock mode the last bit of the slot can be released after half a period. In double-clock mode both access points can move one clock cycle later. The whole frame can also be delayed by 0 to 7 data periods after sync. All configuration and the transmit byte are captured at the frame start, so a change in mid-frame only takes effect in the next frame.

Top module: `pcm_highway_port`

## Requirements
- R1: While reset is applied and after it is released, pcm_tx_oe, rx_valid and pcm_tx_o are 0 until the first transmit access inside the selected slot of a detected frame.
- R2: A frame starts at a rising data clock edge where the sampled sync is 1 and was 0 at the previous rising edge. That edge begins clock cycle 0. With offset field value N (0 to 7), data period 0 of the frame begins N data periods after cycle 0.
- R3: cfg_dbl=0 gives one data clock cycle per data bit. cfg_dbl=1 gives two, with transmit launched in the first cycle of each data period and receive sampled in the second.
- R4: cfg_tx_fall=0 launches transmit data on the rising data clock edge. cfg_tx_fall=1 launches it on the falling edge.
- R5: cfg_rx_rise=0 samples receive data on the falling edge inside the cycle. cfg_rx_rise=1 samples it on the rising edge that ends the cycle.
- R6: In single-clock mode with cfg_bit0_half=1, the slot's last bit (the LSB) is released (pcm_tx_oe=0) at the clock edge opposite to the launch edge. With cfg_bit0_half=0, that bit is driven until the next launch edge.
- R7: In double-clock mode, cfg_bit0_half has no effect: the LSB stays driven until the next launch edge.
- R8: In double-clock mode, cfg_shift=1 moves both the transmit and the receive access points one data clock cycle later.
- R9: cfg_slot=S selects data periods 8S to 8S+7 of the frame. pcm_tx_oe is 1 only for bits launched in that slot.
- R10: The transmit byte is captured at the frame start and sent MSB first. Bit 7 goes in data period 8S and bit 0 in 8S+7.
- R11: The eight receive bits, in order of arrival, form rx_byte with the first bit as the MSB. rx_valid is high for exactly one system clock after the last bit of the slot is sampled.
- R12: The configuration inputs are taken at the frame start and used for the whole frame. A rising-edge receive sample that coincides with a frame start still belongs to the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the data clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pcm_clk | input | 1 | External data clock |
| pcm_fsync | input | 1 | Frame sync pulse |
| pcm_rx_i | input | 1 | Serial receive data |
| cfg_dbl | input | 1 | 1 = two clock cycles per data bit |
| cfg_tx_fall | input | 1 | 1 = launch transmit data on the falling edge |
| cfg_rx_rise | input | 1 | 1 = sample receive data on the rising edge |
| cfg_bit0_half | input | 1 | 1 = release the LSB after half a period (single-clock mode only) |
| cfg_shift | input | 1 | 1 = access points one cycle later (double-clock mode only) |
| cfg_offset | input | 3 | Frame delay in data periods |
| cfg_slot | input | 5 | Time slot number |
| tx_byte | input | 8 | Sample to transmit, captured at the frame start |
| pcm_tx_o | output | 1 | Serial transmit data |
| pcm_tx_oe | output | 1 | Transmit drive enable |
| rx_byte | output | 8 | Last received sample |
| rx_valid | output | 1 | One-cycle strobe for rx_byte |

## Verification
A frame start can fall on the same data clock edge as a receive sample for the old frame, or as a transmit launch for the new frame. The bench drives the configuration inputs and the transmit byte in the middle of each frame, so every frame start also captures new settings. A cycle-level model judges the outcome: on each edge it samples a receive bit with the old settings, captures the new ones, and then launches a transmit bit with them. In single-clock mode, a half-period release of the LSB shares an edge with the receive sample, and the model checks both on that edge.

// File: rtl/pcm_hw_pkg.sv
package pcm_hw_pkg;
  localparam int CYC_W  = 12;
  localparam int SLOT_W = 5;
  localparam int OFS_W  = 3;
  localparam int SAMP_W = 8;
  localparam int IDX_W  = $clog2(SAMP_W);
  localparam logic [CYC_W-1:0] CYC_MAX = {CYC_W{1'b1}};

  typedef struct packed {
    logic              dbl;
    logic              tx_fall;
    logic              rx_rise;
    logic              bit0_half;
    logic              shift;
    logic [OFS_W-1:0]  offset;
    logic [SLOT_W-1:0] slot;
  } cfg_t;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } pos_t;

  // Map a clock-cycle index to a bit position inside the selected slot.
  function automatic pos_t slot_pos(input logic [CYC_W-1:0] kk, input cfg_t c,
                                    input logic rx_side);
    pos_t             r;
    logic             sh;
    logic [CYC_W-1:0] d;
    logic [CYC_W-1:0] q;
    logic [CYC_W-1:0] p;
    r.hit = 1'b0;
    r.idx = '0;
    sh = c.dbl & c.shift;
    d = kk - CYC_W'(sh);
    q = c.dbl ? (d >> 1) : d;
    p = q - CYC_W'(c.offset);
    if ((kk >= CYC_W'(sh)) && (!c.dbl || (d[0] == rx_side)) &&
        (q >= CYC_W'(c.offset)) && ((p >> IDX_W) == CYC_W'(c.slot))) begin
      r.hit = 1'b1;
      r.idx = p[IDX_W-1:0];
    end
    return r;
  endfunction
endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync
  import pcm_hw_pkg::*;
#(
  parameter int NSIG   = 3,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSIG-1:0] raw_i,
  output logic [NSIG-1:0] sync_o,
  output logic            rise_ev,
  output logic            fall_ev
);
  logic [NSIG-1:0] stage_q [STAGES];
  logic            clk_prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= '0;
          else        stage_q[g] <= raw_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= '0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_prev_q <= 1'b0;
    else        clk_prev_q <= sync_o[0];
  end

  assign rise_ev = sync_o[0] & ~clk_prev_q;
  assign fall_ev = ~sync_o[0] & clk_prev_q;
endmodule

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
  import pcm_hw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_ev,
  input  logic              fs_s,
  input  cfg_t              cfg_in,
  input  logic [SAMP_W-1:0] txb_in,
  output cfg_t              cfg_q,
  output cfg_t              cfg_eff,
  output logic [SAMP_W-1:0] txb_eff,
  output logic [CYC_W-1:0]  k_q,
  output logic [CYC_W-1:0]  k_now,
  output logic              framed_q,
  output logic              framed_eff
);
  logic              fs_prev_q;
  logic              frame_det;
  logic [CYC_W-1:0]  k_d;
  logic              fs_prev_d;
  logic              framed_d;
  cfg_t              cfg_d;
  logic [SAMP_W-1:0] txb_q;
  logic [SAMP_W-1:0] txb_d;

  assign frame_det = rise_ev & fs_s & ~fs_prev_q;

  always_comb begin
    k_d       = k_q;
    fs_prev_d = fs_prev_q;
    framed_d  = framed_q;
    cfg_d     = cfg_q;
    txb_d     = txb_q;
    if (rise_ev) begin
      fs_prev_d = fs_s;
      if (frame_det) begin
        k_d      = '0;
        framed_d = 1'b1;
        cfg_d    = cfg_in;
        txb_d    = txb_in;
      end else if (k_q != CYC_MAX) begin
        k_d = k_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q       <= '0;
      fs_prev_q <= 1'b0;
      framed_q  <= 1'b0;
      cfg_q     <= '0;
      txb_q     <= '0;
    end else if (rise_ev) begin
      k_q       <= k_d;
      fs_prev_q <= fs_prev_d;
      framed_q  <= framed_d;
      cfg_q     <= cfg_d;
      txb_q     <= txb_d;
    end
  end

  assign k_now      = rise_ev ? k_d : k_q;
  assign cfg_eff    = frame_det ? cfg_in : cfg_q;
  assign txb_eff    = frame_det ? txb_in : txb_q;
  assign framed_eff = framed_q | frame_det;
endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
  import pcm_hw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_ev,
  input  logic              rel_ev,
  input  cfg_t              cfg_eff,
  input  logic [CYC_W-1:0]  k_now,
  input  logic              framed_eff,
  input  logic [SAMP_W-1:0] txb_eff,
  output logic              pcm_tx_o,
  output logic              pcm_tx_oe
);
  logic tx_q, tx_d;
  logic oe_q, oe_d;
  logic half_q, half_d;
  pos_t pos;

  always_comb begin
    pos    = slot_pos(k_now, cfg_eff, 1'b0);
    tx_d   = tx_q;
    oe_d   = oe_q;
    half_d = half_q;
    if (tx_ev) begin
      if (framed_eff && pos.hit) begin
        tx_d   = txb_eff[IDX_W'(SAMP_W-1) - pos.idx];
        oe_d   = 1'b1;
        half_d = ~cfg_eff.dbl & cfg_eff.bit0_half & (pos.idx == IDX_W'(SAMP_W-1));
      end else begin
        oe_d   = 1'b0;
        half_d = 1'b0;
      end
    end else if (rel_ev && half_q) begin
      oe_d   = 1'b0;
      half_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= 1'b0;
      oe_q   <= 1'b0;
      half_q <= 1'b0;
    end else if (tx_ev || rel_ev) begin
      tx_q   <= tx_d;
      oe_q   <= oe_d;
      half_q <= half_d;
    end
  end

  assign pcm_tx_o  = tx_q;
  assign pcm_tx_oe = oe_q;
endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
  import pcm_hw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_ev,
  input  logic              rx_s,
  input  cfg_t              cfg_q,
  input  logic [CYC_W-1:0]  k_q,
  input  logic              framed_q,
  output logic [SAMP_W-1:0] rx_byte,
  output logic              rx_valid
);
  logic [SAMP_W-1:0] sr_q, sr_d;
  logic [SAMP_W-1:0] out_q, out_d;
  logic              val_d, val_q;
  pos_t              pos;

  always_comb begin
    pos   = slot_pos(k_q, cfg_q, 1'b1);
    sr_d  = sr_q;
    out_d = out_q;
    val_d = 1'b0;
    if (rx_ev && framed_q && pos.hit) begin
      sr_d = {sr_q[SAMP_W-2:0], rx_s};
      if (pos.idx == IDX_W'(SAMP_W-1)) begin
        out_d = sr_d;
        val_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      out_q <= '0;
      val_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      out_q <= out_d;
      val_q <= val_d;
    end
  end

  assign rx_byte  = out_q;
  assign rx_valid = val_q;
endmodule

// File: rtl/pcm_highway_port.sv
module pcm_highway_port
  import pcm_hw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pcm_clk,
  input  logic              pcm_fsync,
  input  logic              pcm_rx_i,
  input  logic              cfg_dbl,
  input  logic              cfg_tx_fall,
  input  logic              cfg_rx_rise,
  input  logic              cfg_bit0_half,
  input  logic              cfg_shift,
  input  logic [OFS_W-1:0]  cfg_offset,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [SAMP_W-1:0] tx_byte,
  output logic              pcm_tx_o,
  output logic              pcm_tx_oe,
  output logic [SAMP_W-1:0] rx_byte,
  output logic              rx_valid
);
  logic [1:0]        rst_pipe;
  logic              rst_q;
  logic [2:0]        sync_v;
  logic              rise_ev, fall_ev;
  logic              tx_ev, rel_ev, rx_ev;
  cfg_t              cfg_in, cfg_cur, cfg_eff;
  logic [SAMP_W-1:0] txb_eff;
  logic [CYC_W-1:0]  k_cur, k_now;
  logic              framed_cur, framed_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  assign cfg_in = '{dbl: cfg_dbl, tx_fall: cfg_tx_fall, rx_rise: cfg_rx_rise,
                    bit0_half: cfg_bit0_half, shift: cfg_shift,
                    offset: cfg_offset, slot: cfg_slot};

  pcm_edge_sync #(.NSIG(3), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_q),
    .raw_i   ({pcm_rx_i, pcm_fsync, pcm_clk}),
    .sync_o  (sync_v),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev)
  );

  pcm_frame_timer u_frame (
    .clk        (clk),
    .rst_n      (rst_q),
    .rise_ev    (rise_ev),
    .fs_s       (sync_v[1]),
    .cfg_in     (cfg_in),
    .txb_in     (tx_byte),
    .cfg_q      (cfg_cur),
    .cfg_eff    (cfg_eff),
    .txb_eff    (txb_eff),
    .k_q        (k_cur),
    .k_now      (k_now),
    .framed_q   (framed_cur),
    .framed_eff (framed_eff)
  );

  assign tx_ev  = cfg_eff.tx_fall ? fall_ev : rise_ev;
  assign rel_ev = cfg_eff.tx_fall ? rise_ev : fall_ev;
  assign rx_ev  = cfg_cur.rx_rise ? rise_ev : fall_ev;

  pcm_tx_lane u_tx (
    .clk        (clk),
    .rst_n      (rst_q),
    .tx_ev      (tx_ev),
    .rel_ev     (rel_ev),
    .cfg_eff    (cfg_eff),
    .k_now      (k_now),
    .framed_eff (framed_eff),
    .txb_eff    (txb_eff),
    .pcm_tx_o   (pcm_tx_o),
    .pcm_tx_oe  (pcm_tx_oe)
  );

  pcm_rx_lane u_rx (
    .clk      (clk),
    .rst_n    (rst_q),
    .rx_ev    (rx_ev),
    .rx_s     (sync_v[2]),
    .cfg_q    (cfg_cur),
    .k_q      (k_cur),
    .framed_q (framed_cur),
    .rx_byte  (rx_byte),
    .rx_valid (rx_valid)
  );
endmodule

// File: rtl/pcm_highway_port_chk.sv
module pcm_highway_port_chk
  import pcm_hw_pkg::*;
(
  input logic clk,
  input logic rst_q,
  input logic tx_ev,
  input logic rx_ev,
  input logic pcm_tx_o,
  input logic pcm_tx_oe,
  input logic rx_valid,
  input cfg_t cfg_cur
);
  // R11: strobe lasts one clock
  a_r11_valid_pulse: assert property (@(posedge clk) disable iff (!rst_q)
    rx_valid |=> !rx_valid);

  // R11: strobe follows a receive sample
  a_r11_valid_after_sample: assert property (@(posedge clk) disable iff (!rst_q)
    rx_valid |-> $past(rx_ev));

  // R9: drive starts only on a launch edge
  a_r9_oe_on_launch: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(pcm_tx_oe) |-> $past(tx_ev));

  // R4: data changes only on a launch edge
  a_r4_data_on_launch: assert property (@(posedge clk) disable iff (!rst_q)
    !$stable(pcm_tx_o) |-> $past(tx_ev));

  // R7: no half-period release in double-clock mode
  a_r7_no_half_release: assert property (@(posedge clk) disable iff (!rst_q)
    ($fell(pcm_tx_oe) && $past(cfg_cur.dbl)) |-> $past(tx_ev));
endmodule

bind pcm_highway_port pcm_highway_port_chk u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .tx_ev     (tx_ev),
  .rx_ev     (rx_ev),
  .pcm_tx_o  (pcm_tx_o),
  .pcm_tx_oe (pcm_tx_oe),
  .rx_valid  (rx_valid),
  .cfg_cur   (cfg_cur)
);

// File: tb/pcm_highway_port_bench.sv
`timescale 1ns/1ps
module pcm_highway_port_bench;
  localparam int FR   = 96;
  localparam int NSC  = 7;
  localparam int KMAX = 4095;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pcm_clk, pcm_fsync, pcm_rx_i;
  logic       cfg_dbl, cfg_tx_fall, cfg_rx_rise, cfg_bit0_half, cfg_shift;
  logic [2:0] cfg_offset;
  logic [4:0] cfg_slot;
  logic [7:0] tx_byte;
  logic       pcm_tx_o, pcm_tx_oe, rx_valid;
  logic [7:0] rx_byte;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  pcm_highway_port u_pcm_highway_port (
    .clk(clk), .rst_n(rst_n), .pcm_clk(pcm_clk), .pcm_fsync(pcm_fsync),
    .pcm_rx_i(pcm_rx_i), .cfg_dbl(cfg_dbl), .cfg_tx_fall(cfg_tx_fall),
    .cfg_rx_rise(cfg_rx_rise), .cfg_bit0_half(cfg_bit0_half),
    .cfg_shift(cfg_shift), .cfg_offset(cfg_offset), .cfg_slot(cfg_slot),
    .tx_byte(tx_byte), .pcm_tx_o(pcm_tx_o), .pcm_tx_oe(pcm_tx_oe),
    .rx_byte(rx_byte), .rx_valid(rx_valid)
  );

  // reference model state
  int m_k = 0;
  bit m_framed = 0, m_fs_prev = 0;
  int m_dbl = 0, m_txf = 0, m_rxr = 0, m_half = 0, m_sh = 0, m_off = 0, m_slot = 0;
  int m_txb = 0, m_rxsr = 0;
  bit oe_e = 0, tx_e = 0, hp = 0;
  int exp_q[$];
  int n_exp = 0, n_got = 0;
  int cur_sc = 0;
  logic [15:0] lf = 16'hACE1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag(input int s);
    case (s)
      0: tag = "R2 R4 R9 R10";
      1: tag = "R4 R5 R6 R2 R12";
      2: tag = "R3 R7 R12";
      3: tag = "R3 R8 R2 R12";
      4: tag = "R6 R5 R12";
      5: tag = "R8 R5 R12";
      default: tag = "R12 R10";
    endcase
  endfunction

  task automatic apply_cfg(input int s);
    cfg_dbl       = (s == 2 || s == 3 || s == 5);
    cfg_tx_fall   = (s == 1 || s == 3 || s == 6);
    cfg_rx_rise   = (s == 1 || s == 4 || s == 5);
    cfg_bit0_half = (s == 1 || s == 2 || s == 4);
    cfg_shift     = (s == 3 || s == 5);
    case (s)
      0: begin cfg_offset = 3'd0; cfg_slot = 5'd0; end
      1: begin cfg_offset = 3'd3; cfg_slot = 5'd2; end
      2: begin cfg_offset = 3'd1; cfg_slot = 5'd1; end
      3: begin cfg_offset = 3'd7; cfg_slot = 5'd2; end
      4: begin cfg_offset = 3'd7; cfg_slot = 5'd5; end
      5: begin cfg_offset = 3'd0; cfg_slot = 5'd0; end
      default: begin cfg_offset = 3'd5; cfg_slot = 5'd4; end
    endcase
    tx_byte = 8'(8'hA5 ^ (s * 37));
  endtask

  // bit position within the slot, -1 when outside
  function automatic int slot_bit(input int kk, input bit rx);
    int sh, d, q, p;
    sh = (m_dbl != 0 && m_sh != 0) ? 1 : 0;
    if (kk < sh) return -1;
    d = kk - sh;
    if (m_dbl != 0 && (d % 2) != (rx ? 1 : 0)) return -1;
    q = (m_dbl != 0) ? d / 2 : d;
    if (q < m_off) return -1;
    p = q - m_off;
    if (p / 8 != m_slot) return -1;
    return p % 8;
  endfunction

  task automatic do_rx();
    int i;
    if (!m_framed) return;
    i = slot_bit(m_k, 1);
    if (i >= 0) begin
      m_rxsr = ((m_rxsr << 1) | int'(pcm_rx_i)) & 255;
      if (i == 7) begin exp_q.push_back(m_rxsr); n_exp++; end
    end
  endtask

  task automatic do_tx();
    int i;
    i = m_framed ? slot_bit(m_k, 0) : -1;
    if (i >= 0) begin
      tx_e = ((m_txb >> (7 - i)) & 1) != 0;
      oe_e = 1;
      hp   = (m_dbl == 0) && (m_half != 0) && (i == 7);
    end else begin
      oe_e = 0;
      hp   = 0;
    end
  endtask

  task automatic do_rel();
    if (hp) begin oe_e = 0; hp = 0; end
  endtask

  task automatic model_edge(input bit rising);
    if (rising) begin
      if (m_rxr != 0) do_rx();
      if (pcm_fsync && !m_fs_prev) begin
        m_dbl = cfg_dbl; m_txf = cfg_tx_fall; m_rxr = cfg_rx_rise;
        m_half = cfg_bit0_half; m_sh = cfg_shift; m_off = cfg_offset;
        m_slot = cfg_slot; m_txb = tx_byte;
        m_k = 0; m_framed = 1;
      end else if (m_k < KMAX) begin
        m_k++;
      end
      m_fs_prev = pcm_fsync;
      if (m_txf == 0) do_tx(); else do_rel();
    end else begin
      if (m_rxr == 0) do_rx();
      if (m_txf != 0) do_tx(); else do_rel();
    end
  endtask

  // one half period of the data clock: 8 system clocks
  task automatic half(input bit level, input bit fs_next);
    pcm_clk = level;
    model_edge(level);
    repeat (4) @(negedge clk);
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    pcm_rx_i  = lf[0];
    pcm_fsync = fs_next;
    repeat (2) @(negedge clk);
    check(pcm_tx_oe == oe_e, {tag(cur_sc), " R9 oe"}, pcm_tx_oe, oe_e);
    if (oe_e) check(pcm_tx_o == tx_e, {tag(cur_sc), " R10 data"}, pcm_tx_o, tx_e);
    repeat (2) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rx_valid) begin
      n_got++;
      if (exp_q.size() == 0) check(0, "R11 unexpected strobe", rx_byte, -1);
      else check(rx_byte == 8'(exp_q.pop_front()), {tag(cur_sc), " R11 rx byte"},
                 rx_byte, -1);
    end
  end

  initial begin
    rst_n = 1'b0;
    pcm_clk = 1'b0; pcm_fsync = 1'b0; pcm_rx_i = 1'b0;
    apply_cfg(0);
    repeat (4) @(negedge clk);
    check(pcm_tx_oe == 1'b0, "R1 oe in reset", pcm_tx_oe, 0);
    check(rx_valid == 1'b0, "R1 valid in reset", rx_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(pcm_tx_oe == 1'b0, "R1 oe after reset", pcm_tx_oe, 0);
    check(rx_valid == 1'b0, "R1 valid after reset", rx_valid, 0);
    check(pcm_tx_o == 1'b0, "R1 data after reset", pcm_tx_o, 0);
    // lead-in cycle raises sync before the first frame
    half(1'b1, 1'b0);
    half(1'b0, 1'b1);
    for (int f = 0; f < NSC; f++) begin
      cur_sc = f;
      for (int c = 0; c < FR; c++) begin
        if (c == 40 && f + 1 < NSC) apply_cfg(f + 1);
        half(1'b1, pcm_fsync);
        half(1'b0, (c == FR - 1) && (f + 1 < NSC));
      end
    end
    repeat (8) @(negedge clk);
    check(n_got == n_exp, "R11 strobe count", n_got, n_exp);
    check(n_exp == NSC, "R11 bytes per frame", n_exp, NSC);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule